// File: doc/BRIEF.md
# Cartridge Slice Bank Controller with Address-Encoded Delayed Writes

This block sits on the cartridge side of an 8-bit CPU bus and serves a 4 KB window, selected by address bit 12. The window is cut into a lower and an upper 2 KB slice, chosen by address bit 11. A configuration register maps each slice onto one of four 2 KB banks. Banks 0 to 2 are RAM and bank 3 is a read-only bank with fixed contents.

The bus has no write strobe, so RAM is written through the pattern of read addresses. An access to the first 256 bytes of the window latches its low address byte into a hold register and arms a write. The held byte is then written on exactly the fifth distinct bus access that follows, at that access's address. A single hotspot address copies the hold register into the configuration register. This is how software selects the slice mapping, enables writes and switches off power to the read-only bank.

Every clock cycle carries one address. A cycle counts as a new access only when its address differs from the previous cycle's address. Read data is combinational and reflects the state at the start of the cycle. Any state change made by an access is visible from the next cycle on.

Top module: `slice_bank_ctrl`

## Requirements
- R1: After reset the configuration register is zero. The lower slice maps to RAM bank 2 and the upper slice to the read-only bank, writes are disabled, the read-only bank is powered, and no write is pending.
- R2: A read returns the byte at offset addr[10:0] of the bank mapped to the slice chosen by addr[11]. Mapping codes 0 to 7 give (lower, upper) as: 0:(2,ROM) 1:(0,ROM) 2:(2,0) 3:(0,2) 4:(2,ROM) 5:(1,ROM) 6:(2,1) 7:(1,2).
- R3: A new access with addr[12]=1 and addr[11:8]=0 loads addr[7:0] into the hold register and arms a write, with its distinct-access count restarted. This happens only when writes are disabled or no write is pending.
- R4: A new access with addr[12:0]=0x1FF8 copies the hold register into the configuration register and clears any pending write. No other access changes the configuration.
- R5: With writes enabled and a write pending, the held byte is written on the fifth new access after the arming access, provided that access lies in the window. The fourth access writes nothing. The pending write then clears. A target in the first 256 bytes of the window is written rather than re-armed.
- R6: A new access is a cycle whose address differs from the previous cycle's address, or the first cycle after reset. Repeated cycles at the same address are not counted.
- R7: A pending write that has seen more than 5 new accesses without committing is cancelled and writes nothing.
- R8: A commit goes to the lower slice when addr[11]=0 and to the upper slice when addr[11]=1. A commit aimed at a slice mapped to the read-only bank is dropped, and no RAM changes.
- R9: Configuration byte fields are as follows. Bit 0 switches off read-only bank power (1 = off). Bit 1 enables writes (1 = on). Bits 4:2 hold the mapping code. Bits 7:5 are ignored.
- R10: While bit 0 of the configuration is 1, reads of a slice mapped to the read-only bank return 0xFF. RAM reads are unaffected.
- R11: Read-only bank byte k (k = 0..2047) is k[7:0] XOR 0x5A XOR (k[10:8] shifted left by 5).
- R12: With write enable 0, an armed write never commits, and RAM keeps its contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, one address per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 13 | CPU address; bit 12 selects the cartridge window |
| rd_data | output | 8 | Byte read from the mapped bank at bus_addr |

## Verification
On every cycle, the assertions check the following sequencer rules. The configuration moves only on a hotspot access, and the hotspot always leaves nothing pending. An arming access always leaves a fresh pending write holding its low address byte. A pending write never ages past the commit gap, and a commit only fires when the age is one short of the gap. The bench scenarios are the only way to show the data results. These are the full mapping table, the exact fifth-access commit (with a repeated address not counted), expiry, dropped writes to the read-only bank, the power-off read value and the ignored pulse-delay bits.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

   typedef enum logic [1:0] {
      BK_RAM0 = 2'd0,
      BK_RAM1 = 2'd1,
      BK_RAM2 = 2'd2,
      BK_ROM  = 2'd3
   } bank_e;

   typedef struct packed {
      logic [2:0] map_code;
      logic       wr_en;
      logic       rom_off;
   } cfg_t;

   function automatic bank_e lower_bank(input logic [2:0] code);
      case (code)
         3'd1, 3'd3: lower_bank = BK_RAM0;
         3'd5, 3'd7: lower_bank = BK_RAM1;
         default:    lower_bank = BK_RAM2;
      endcase
   endfunction

   function automatic bank_e upper_bank(input logic [2:0] code);
      case (code)
         3'd2:       upper_bank = BK_RAM0;
         3'd6:       upper_bank = BK_RAM1;
         3'd3, 3'd7: upper_bank = BK_RAM2;
         default:    upper_bank = BK_ROM;
      endcase
   endfunction

endpackage

// File: rtl/sbc_access_seq.sv
module sbc_access_seq
   import sbc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 13,
   parameter int unsigned SLICE_AW   = 11,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned COMMIT_GAP = 5,
   parameter logic [ADDR_W-1:0] HOTSPOT = 13'h1FF8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   addr,
   output cfg_t                cfg,
   output logic                cm_valid,
   output logic                cm_upper,
   output logic [SLICE_AW-1:0] cm_off,
   output logic [DATA_W-1:0]   cm_data
);
   localparam int unsigned AGE_W = $clog2(COMMIT_GAP + 2);
   localparam logic [AGE_W-1:0] GAP_A = AGE_W'(COMMIT_GAP);
   localparam logic [AGE_W-1:0] SAT_A = AGE_W'(COMMIT_GAP + 1);
   localparam int unsigned PAGE_HI = ADDR_W - 2;

   logic [ADDR_W-1:0] prev_q;
   logic              seen_q;
   logic              pend_q;
   logic [AGE_W-1:0]  age_q;
   logic [DATA_W-1:0] hold_q;
   cfg_t              cfg_q;

   logic             new_acc, in_win, low_pg, hot, live;
   logic             do_arm, do_cfg, do_commit;
   logic [AGE_W-1:0] age_inc;

   always_comb begin
      new_acc   = !seen_q || (addr != prev_q);
      in_win    = addr[ADDR_W-1];
      low_pg    = in_win && (addr[PAGE_HI:DATA_W] == '0);
      hot       = (addr == HOTSPOT);
      age_inc   = (age_q == SAT_A) ? age_q : age_q + 1'b1;
      live      = pend_q && (age_inc <= GAP_A);
      do_arm    = new_acc && low_pg && (!cfg_q.wr_en || !live);
      do_cfg    = new_acc && !do_arm && hot;
      do_commit = new_acc && !do_arm && !hot && in_win && cfg_q.wr_en
                  && live && (age_inc == GAP_A);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         seen_q <= 1'b0;
         pend_q <= 1'b0;
         age_q  <= '0;
         hold_q <= '0;
         cfg_q  <= '0;
      end else begin
         prev_q <= addr;
         seen_q <= 1'b1;
         if (new_acc) begin
            if (do_arm) begin
               hold_q <= addr[DATA_W-1:0];
               pend_q <= 1'b1;
               age_q  <= '0;
            end else if (do_cfg) begin
               pend_q <= 1'b0;
               cfg_q  <= cfg_t'(hold_q[$bits(cfg_t)-1:0]);
            end else if (do_commit) begin
               pend_q <= 1'b0;
            end else begin
               pend_q <= live;
               if (pend_q) age_q <= age_inc;
            end
         end
      end
   end

   assign cfg      = cfg_q;
   assign cm_valid = do_commit;
   assign cm_upper = addr[SLICE_AW];
   assign cm_off   = addr[SLICE_AW-1:0];
   assign cm_data  = hold_q;

   // R4: configuration only moves on the hotspot address
   p_cfg_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (addr != HOTSPOT) |=> $stable(cfg_q));

   // R4: hotspot access leaves nothing pending
   p_hot_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (new_acc && hot) |=> !pend_q);

   // R3: arming with writes off records the low address byte
   p_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (new_acc && low_pg && !cfg_q.wr_en) |=>
         (pend_q && (age_q == '0) && (hold_q == $past(addr[DATA_W-1:0]))));

   // R7: a pending write never ages past the commit gap
   p_age_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> (age_q <= GAP_A));

   // R5: commit only one access short of the gap age
   p_commit_age_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cm_valid |-> (pend_q && (age_q == GAP_A - 1'b1)));

endmodule

// File: rtl/sbc_ram_bank.sv
module sbc_ram_bank #(
   parameter int unsigned AW = 11,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/sbc_rom_bank.sv
module sbc_rom_bank #(
   parameter int unsigned AW = 11,
   parameter int unsigned DW = 8
) (
   input  logic          rom_off,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int unsigned HI_W = AW - 8;

   logic [DW-1:0] hi_part;
   logic [DW-1:0] pattern;

   always_comb begin
      hi_part = DW'({raddr[AW-1:8], 5'b0});
      pattern = DW'(raddr[7:0]) ^ DW'(8'h5A) ^ hi_part;
      rdata   = rom_off ? '1 : pattern;
   end
endmodule

// File: rtl/slice_bank_ctrl.sv
module slice_bank_ctrl
   import sbc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 13,
   parameter int unsigned SLICE_AW   = 11,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned COMMIT_GAP = 5,
   parameter logic [ADDR_W-1:0] HOTSPOT = 13'h1FF8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned NUM_RAM = 3;

   if (ADDR_W != SLICE_AW + 2) begin : g_bad_addr
      $error("ADDR_W must equal SLICE_AW + 2");
   end
   if (DATA_W != 8) begin : g_bad_data
      $error("DATA_W must be 8");
   end
   if (SLICE_AW < 9 || SLICE_AW > 12) begin : g_bad_slice
      $error("SLICE_AW out of range");
   end
   if (COMMIT_GAP < 1) begin : g_bad_gap
      $error("COMMIT_GAP must be at least 1");
   end

   cfg_t                cfg;
   logic                cm_valid, cm_upper;
   logic [SLICE_AW-1:0] cm_off;
   logic [DATA_W-1:0]   cm_data;
   bank_e               rd_bank, wr_bank;
   logic [NUM_RAM-1:0]  ram_we;
   logic [DATA_W-1:0]   ram_rd [NUM_RAM];
   logic [DATA_W-1:0]   rom_rd;

   sbc_access_seq #(
      .ADDR_W(ADDR_W), .SLICE_AW(SLICE_AW), .DATA_W(DATA_W),
      .COMMIT_GAP(COMMIT_GAP), .HOTSPOT(HOTSPOT)
   ) seq_i (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .cfg(cfg),
      .cm_valid(cm_valid), .cm_upper(cm_upper), .cm_off(cm_off),
      .cm_data(cm_data)
   );

   assign wr_bank = cm_upper ? upper_bank(cfg.map_code) : lower_bank(cfg.map_code);
   assign rd_bank = bus_addr[SLICE_AW] ? upper_bank(cfg.map_code)
                                       : lower_bank(cfg.map_code);

   for (genvar g = 0; g < NUM_RAM; g++) begin : g_ram
      assign ram_we[g] = cm_valid && (wr_bank == bank_e'(2'(g)));
      sbc_ram_bank #(.AW(SLICE_AW), .DW(DATA_W)) ram_i (
         .clk(clk), .we(ram_we[g]), .waddr(cm_off), .wdata(cm_data),
         .raddr(bus_addr[SLICE_AW-1:0]), .rdata(ram_rd[g])
      );
   end

   sbc_rom_bank #(.AW(SLICE_AW), .DW(DATA_W)) rom_i (
      .rom_off(cfg.rom_off), .raddr(bus_addr[SLICE_AW-1:0]), .rdata(rom_rd)
   );

   always_comb begin
      case (rd_bank)
         BK_RAM0: rd_data = ram_rd[0];
         BK_RAM1: rd_data = ram_rd[1];
         BK_RAM2: rd_data = ram_rd[2];
         default: rd_data = rom_rd;
      endcase
   end
endmodule

// File: tb/slice_bank_ctrl_tb_top.sv
module slice_bank_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [12:0] bus_addr = '0;
   logic [7:0]  rd_data;
   int          total = 0;
   int          failed = 0;
   logic [7:0]  fcnt = '0;

   always #4 clk = ~clk;

   slice_bank_ctrl dut_i (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .rd_data(rd_data));

   function automatic logic [7:0] rom_exp(input logic [10:0] k);
      return k[7:0] ^ 8'h5A ^ {k[10:8], 5'b0};
   endfunction

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      total++;
      if (got !== exp) begin
         failed++;
         $display("FAIL %s: got %02h expected %02h", tag, got, exp);
      end
   endtask

   task automatic acc(input logic [12:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = rd_data;
   endtask

   task automatic go(input logic [12:0] a);
      logic [7:0] d;
      acc(a, d);
   endtask

   task automatic rd(input string tag, input logic [12:0] a, input logic [7:0] exp);
      logic [7:0] d;
      acc(a, d);
      chk(tag, d, exp);
   endtask

   task automatic filler();
      go({5'b00010, fcnt});
      fcnt++;
   endtask

   task automatic flush();
      for (int i = 0; i < 6; i++) filler();
   endtask

   task automatic set_cfg(input logic [7:0] v);
      flush();
      go({5'b10000, v});
      go(13'h1FF8);
   endtask

   task automatic poke(input logic [12:0] a, input logic [7:0] v);
      flush();
      go({5'b10000, v});
      for (int i = 0; i < 4; i++) filler();
      go(a);
   endtask

   task automatic t_reset();
      rd("R1 R11 upper maps ROM after reset", 13'h1800, rom_exp(11'h000));
      rd("R11 ROM pattern", 13'h1A34, rom_exp(11'h234));
   endtask

   task automatic t_mapping();
      set_cfg(8'h0E);
      poke(13'h1123, 8'h11);
      poke(13'h1923, 8'h22);
      rd("R2 code3 lower=bank0", 13'h1123, 8'h11);
      rd("R2 code3 upper=bank2", 13'h1923, 8'h22);
      set_cfg(8'h0A);
      rd("R2 code2 lower=bank2", 13'h1123, 8'h22);
      rd("R2 code2 upper=bank0", 13'h1923, 8'h11);
      set_cfg(8'h1A);
      poke(13'h1923, 8'h33);
      rd("R2 code6 lower=bank2", 13'h1123, 8'h22);
      set_cfg(8'h16);
      rd("R2 code5 lower=bank1", 13'h1123, 8'h33);
      rd("R2 code5 upper=ROM", 13'h1923, rom_exp(11'h123));
      set_cfg(8'h1E);
      rd("R2 code7 lower=bank1", 13'h1123, 8'h33);
      rd("R2 code7 upper=bank2", 13'h1923, 8'h22);
      set_cfg(8'h12);
      rd("R2 code4 lower=bank2", 13'h1123, 8'h22);
      rd("R2 code4 upper=ROM", 13'h1923, rom_exp(11'h123));
      set_cfg(8'h06);
      rd("R2 code1 lower=bank0", 13'h1123, 8'h11);
      set_cfg(8'h02);
      rd("R2 code0 lower=bank2", 13'h1123, 8'h22);
   endtask

   task automatic t_rom_drop();
      set_cfg(8'h06);
      poke(13'h1923, 8'hAB);
      rd("R8 write to ROM slice dropped", 13'h1923, rom_exp(11'h123));
      poke(13'h1124, 8'h55);
      rd("R8 lower slice write lands", 13'h1124, 8'h55);
      set_cfg(8'h16);
      rd("R8 bank1 untouched by dropped write", 13'h1923 ^ 13'h0800, 8'h33);
      set_cfg(8'h06);
   endtask

   task automatic t_exact_count();
      flush();
      go(13'h1044);
      go(13'h0300);
      go(13'h0301);
      go(13'h0301);   // repeat, not a new access (R6)
      go(13'h0302);
      go(13'h1124);   // 4th new access: no write
      go(13'h1125);   // 5th new access: commit
      rd("R5 R6 fourth access not written", 13'h1124, 8'h55);
      rd("R5 fifth access written", 13'h1125, 8'h44);
      poke(13'h1010, 8'h42);
      rd("R5 low-page target committed", 13'h1010, 8'h42);
   endtask

   task automatic t_expire();
      poke(13'h1126, 8'h77);
      flush();
      go(13'h1066);
      for (int i = 0; i < 5; i++) filler();
      go(13'h1126);
      rd("R7 expired write cancelled", 13'h1126, 8'h77);
   endtask

   task automatic t_we_off();
      set_cfg(8'h04);
      poke(13'h1124, 8'h99);
      rd("R12 R9 write disabled keeps RAM", 13'h1124, 8'h55);
   endtask

   task automatic t_hot_cancel();
      set_cfg(8'h06);
      poke(13'h1127, 8'h5C);
      flush();
      go(13'h100E);
      go(13'h1FF8);
      filler();
      filler();
      filler();
      go(13'h1127);
      rd("R4 hotspot cancelled pending", 13'h1127, 8'h5C);
      rd("R4 hotspot loaded code3", 13'h1923, 8'h22);
   endtask

   task automatic t_rom_power();
      set_cfg(8'h07);
      rd("R10 ROM off reads FF", 13'h1923, 8'hFF);
      rd("R10 RAM unaffected by ROM off", 13'h1123, 8'h11);
      set_cfg(8'h06);
      rd("R10 ROM powered again", 13'h1923, rom_exp(11'h123));
   endtask

   task automatic t_pulse_ignored();
      set_cfg(8'hEE);
      rd("R9 pulse bits ignored lower", 13'h1123, 8'h11);
      rd("R9 pulse bits ignored upper", 13'h1923, 8'h22);
      poke(13'h1128, 8'h3C);
      rd("R9 write enable still honoured", 13'h1128, 8'h3C);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      total++;
      failed++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_mapping();
      t_rom_drop();
      t_exact_count();
      t_expire();
      t_we_off();
      t_hot_cancel();
      t_rom_power();
      t_pulse_ignored();
      summary();
   end
endmodule